// File: doc/BRIEF.md
# Word-Addressed GPIO Register Block

This block is a general-purpose I/O peripheral for a set of pins (32 by default). It has a word-wide register interface with a simple request signal and one request per cycle. Software reads and writes a small set of registers at fixed byte offsets. The block drives two vectors toward the pad ring: an output-enable taken from the direction register, and an output value taken from the stored pin-level register. Reading the level offset returns the stored register, not the external pins.

Pin levels change only through two write-only mask ports, one that sets bits and one that clears them. A mask write is honoured only when it overlaps at least one pin configured as output. When it is honoured, the whole mask lands, including bits for input pins. A mask write that touches only input pins is refused and produces an error pulse. Illegal offsets also produce the error pulse. The block also has a free read/write scratch word and three edge-configuration slots that accept writes and do nothing. The interrupt lines exist as ports and are held low.

Top module: `gpio_regblock`

## Requirements
- R1: While reset is asserted and right after it is released, pin_oe, pin_out, rsp_rdata, acc_err and all interrupt outputs are zero, and the level, direction and scratch registers read as zero.
- R2: A read request (req_valid=1, req_write=0) places its data on rsp_rdata at the next clock edge, from these offsets: level 0x00, direction 0x04, scratch 0x20. rsp_rdata keeps its value in every cycle that has no read.
- R3: A write to offset 0x04 loads the direction register, and pin_oe shows the new value after the next clock edge.
- R4: A write to offset 0x08 whose mask has a bit set under a 1 in the direction register ORs the entire mask into the level register, which pin_out shows after the next edge.
- R5: A write to offset 0x0C whose mask has a bit set under a 1 in the direction register clears every masked bit of the level register.
- R6: A write to offset 0x08 or 0x0C whose mask shares no bit with the direction register leaves the level register unchanged and raises acc_err.
- R7: Writes to offsets 0x10, 0x14 and 0x18 change no register and no output, and raise no error.
- R8: A read from any offset other than 0x00, 0x04 or 0x20 returns zero on rsp_rdata and raises acc_err. A write to any offset other than 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 or 0x20 changes nothing and raises acc_err. Offsets that are not word-aligned are illegal.
- R9: acc_err is high only in the cycle right after an offending request. A cycle with no request, or with a legal request, is followed by acc_err low.
- R10: irq_low (one line per low pin, 8 lines) and irq_high stay zero at all times.
- R11: A write to offset 0x20 stores the word for later reads and leaves pin_oe and pin_out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset of the access |
| req_wdata | input | PIN_W (32) | Write data or mask |
| rsp_rdata | output | PIN_W (32) | Registered read data, held between reads |
| acc_err | output | 1 | One-cycle error pulse after an offending request |
| pin_oe | output | PIN_W (32) | Output enable per pin (direction register) |
| pin_out | output | PIN_W (32) | Output level per pin (level register) |
| irq_low | output | LOW_IRQ (8) | Per-pin interrupt lines, held low |
| irq_high | output | 1 | Group interrupt line, held low |

## Verification
Two things can surface in the same cycle: the error pulse from a refused set or clear write, and the read data of the request that follows it. The bench issues a set or clear mask aimed only at input pins and follows it at once with a read of the level register. It then checks, at that one sampling point, that the error pulse is there, that it lasts one cycle, and that the returned level matches the unchanged model. It also puts a legal write right after an illegal read, so the pulse must end even though requests keep arriving.

// File: rtl/gpio_regblock_pkg.sv
package gpio_regblock_pkg;

  // Byte offsets of the register window (word aligned)
  localparam int unsigned OFS_LEVEL = 32'h00;
  localparam int unsigned OFS_DIR   = 32'h04;
  localparam int unsigned OFS_SET   = 32'h08;
  localparam int unsigned OFS_CLR   = 32'h0C;
  localparam int unsigned OFS_EDGR  = 32'h10;
  localparam int unsigned OFS_EDGF  = 32'h14;
  localparam int unsigned OFS_EDGS  = 32'h18;
  localparam int unsigned OFS_SCR   = 32'h20;

  typedef enum logic [3:0] {
    OP_IDLE,
    OP_RD_LEVEL,
    OP_RD_DIR,
    OP_RD_SCR,
    OP_RD_BAD,
    OP_WR_DIR,
    OP_WR_SET,
    OP_WR_CLR,
    OP_WR_SCR,
    OP_WR_NOP,
    OP_WR_BAD
  } bus_op_e;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_regblock_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output bus_op_e           op
);

  always_comb begin
    op = OP_IDLE;
    if (req_valid) begin
      if (req_write) begin
        if      (req_addr == ADDR_W'(OFS_DIR))  op = OP_WR_DIR;
        else if (req_addr == ADDR_W'(OFS_SET))  op = OP_WR_SET;
        else if (req_addr == ADDR_W'(OFS_CLR))  op = OP_WR_CLR;
        else if (req_addr == ADDR_W'(OFS_SCR))  op = OP_WR_SCR;
        else if (req_addr == ADDR_W'(OFS_EDGR) ||
                 req_addr == ADDR_W'(OFS_EDGF) ||
                 req_addr == ADDR_W'(OFS_EDGS)) op = OP_WR_NOP;
        else                                    op = OP_WR_BAD;
      end else begin
        if      (req_addr == ADDR_W'(OFS_LEVEL)) op = OP_RD_LEVEL;
        else if (req_addr == ADDR_W'(OFS_DIR))   op = OP_RD_DIR;
        else if (req_addr == ADDR_W'(OFS_SCR))   op = OP_RD_SCR;
        else                                     op = OP_RD_BAD;
      end
    end
  end

endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
  import gpio_regblock_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_op_e          op,
  input  logic [PIN_W-1:0] wdata,
  output logic [PIN_W-1:0] level_q,
  output logic [PIN_W-1:0] dir_q,
  output logic [PIN_W-1:0] scr_q,
  output logic             mask_reject
);

  logic             mask_hit;
  logic             level_en;
  logic             dir_en;
  logic             scr_en;
  logic [PIN_W-1:0] level_d;

  // A mask write counts only if it reaches at least one output pin
  assign mask_hit    = |(dir_q & wdata);
  assign mask_reject = (op == OP_WR_SET || op == OP_WR_CLR) && !mask_hit;

  always_comb begin
    level_en = 1'b0;
    level_d  = level_q;
    dir_en   = (op == OP_WR_DIR);
    scr_en   = (op == OP_WR_SCR);
    if (op == OP_WR_SET && mask_hit) begin
      level_en = 1'b1;
      level_d  = level_q | wdata;
    end else if (op == OP_WR_CLR && mask_hit) begin
      level_en = 1'b1;
      level_d  = level_q & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      dir_q   <= '0;
      scr_q   <= '0;
    end else begin
      if (level_en) level_q <= level_d;
      if (dir_en)   dir_q   <= wdata;
      if (scr_en)   scr_q   <= wdata;
    end
  end

endmodule

// File: rtl/gpio_rsp_stage.sv
module gpio_rsp_stage
  import gpio_regblock_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_op_e          op,
  input  logic             mask_reject,
  input  logic [PIN_W-1:0] level_q,
  input  logic [PIN_W-1:0] dir_q,
  input  logic [PIN_W-1:0] scr_q,
  output logic [PIN_W-1:0] rdata_q,
  output logic             err_q
);

  logic             rd_en;
  logic [PIN_W-1:0] rdata_d;
  logic             err_d;

  always_comb begin
    rd_en   = 1'b1;
    rdata_d = '0;
    unique case (op)
      OP_RD_LEVEL: rdata_d = level_q;
      OP_RD_DIR:   rdata_d = dir_q;
      OP_RD_SCR:   rdata_d = scr_q;
      OP_RD_BAD:   rdata_d = '0;
      default:     rd_en   = 1'b0;
    endcase
    err_d = (op == OP_RD_BAD) || (op == OP_WR_BAD) || mask_reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rdata_d;
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock
  import gpio_regblock_pkg::*;
#(
  parameter int PIN_W   = 32,
  parameter int ADDR_W  = 8,
  parameter int LOW_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [PIN_W-1:0]   req_wdata,
  output logic [PIN_W-1:0]   rsp_rdata,
  output logic               acc_err,
  output logic [PIN_W-1:0]   pin_oe,
  output logic [PIN_W-1:0]   pin_out,
  output logic [LOW_IRQ-1:0] irq_low,
  output logic               irq_high
);

  bus_op_e          op;
  logic [PIN_W-1:0] level_q;
  logic [PIN_W-1:0] dir_q;
  logic [PIN_W-1:0] scr_q;
  logic             mask_reject;

  gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .op        (op)
  );

  gpio_pin_regs #(.PIN_W(PIN_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .wdata       (req_wdata),
    .level_q     (level_q),
    .dir_q       (dir_q),
    .scr_q       (scr_q),
    .mask_reject (mask_reject)
  );

  gpio_rsp_stage #(.PIN_W(PIN_W)) u_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .mask_reject (mask_reject),
    .level_q     (level_q),
    .dir_q       (dir_q),
    .scr_q       (scr_q),
    .rdata_q     (rsp_rdata),
    .err_q       (acc_err)
  );

  assign pin_oe  = dir_q;
  assign pin_out = level_q;

  // Interrupt lines are placeholders, tied inactive
  for (genvar g = 0; g < LOW_IRQ; g++) begin : g_irq_low
    assign irq_low[g] = 1'b0;
  end
  assign irq_high = 1'b0;

endmodule

// File: rtl/gpio_regblock_chk.sv
module gpio_regblock_chk
  import gpio_regblock_pkg::*;
#(
  parameter int PIN_W   = 32,
  parameter int ADDR_W  = 8,
  parameter int LOW_IRQ = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [PIN_W-1:0]   req_wdata,
  input logic [PIN_W-1:0]   rsp_rdata,
  input logic               acc_err,
  input logic [PIN_W-1:0]   pin_oe,
  input logic [PIN_W-1:0]   pin_out,
  input logic [LOW_IRQ-1:0] irq_low,
  input logic               irq_high
);

  logic wr_set, wr_clr, wr_dir, wr_edge, wr_scr, rd_any, rd_bad, masks_out;

  assign wr_set    = req_valid && req_write && req_addr == ADDR_W'(OFS_SET);
  assign wr_clr    = req_valid && req_write && req_addr == ADDR_W'(OFS_CLR);
  assign wr_dir    = req_valid && req_write && req_addr == ADDR_W'(OFS_DIR);
  assign wr_scr    = req_valid && req_write && req_addr == ADDR_W'(OFS_SCR);
  assign wr_edge   = req_valid && req_write &&
                     (req_addr == ADDR_W'(OFS_EDGR) || req_addr == ADDR_W'(OFS_EDGF) ||
                      req_addr == ADDR_W'(OFS_EDGS));
  assign rd_any    = req_valid && !req_write;
  assign rd_bad    = rd_any && req_addr != ADDR_W'(OFS_LEVEL) &&
                     req_addr != ADDR_W'(OFS_DIR) && req_addr != ADDR_W'(OFS_SCR);
  assign masks_out = (pin_oe & req_wdata) != '0;

  p_dir_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == $past(req_wdata));

  p_set_apply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && masks_out) |=> pin_out == ($past(pin_out) | $past(req_wdata)));

  p_clr_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && masks_out) |=> pin_out == ($past(pin_out) & ~$past(req_wdata)));

  p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_set || wr_clr) && !masks_out) |=> acc_err && $stable(pin_out));

  p_edge_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_edge |=> !acc_err && $stable(pin_out) && $stable(pin_oe));

  p_bad_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |=> acc_err && rsp_rdata == '0);

  p_idle_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !acc_err);

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> $stable(rsp_rdata));

  p_scr_no_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_scr |=> $stable(pin_out) && $stable(pin_oe));

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_low == '0 && !irq_high);

endmodule

bind gpio_regblock gpio_regblock_chk #(
  .PIN_W(PIN_W), .ADDR_W(ADDR_W), .LOW_IRQ(LOW_IRQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
  .acc_err(acc_err), .pin_oe(pin_oe), .pin_out(pin_out),
  .irq_low(irq_low), .irq_high(irq_high)
);

// File: tb/gpio_regblock_test.sv
module gpio_regblock_test;

  localparam int PIN_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int LOW_IRQ = 8;

  logic               clk;
  logic               rst_n;
  logic               req_valid;
  logic               req_write;
  logic [ADDR_W-1:0]  req_addr;
  logic [PIN_W-1:0]   req_wdata;
  logic [PIN_W-1:0]   rsp_rdata;
  logic               acc_err;
  logic [PIN_W-1:0]   pin_oe;
  logic [PIN_W-1:0]   pin_out;
  logic [LOW_IRQ-1:0] irq_low;
  logic               irq_high;

  gpio_regblock #(.PIN_W(PIN_W), .ADDR_W(ADDR_W), .LOW_IRQ(LOW_IRQ)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .acc_err(acc_err), .pin_oe(pin_oe), .pin_out(pin_out),
    .irq_low(irq_low), .irq_high(irq_high)
  );

  // 250 MHz
  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    string       tag;
    longint      due;
    logic [31:0] rdata;
    logic        err;
    logic [31:0] pout;
    logic [31:0] poe;
  } exp_t;

  exp_t   sb[$];
  longint cyc = 0;
  int     n_chk = 0;
  int     n_fail = 0;
  bit     done = 1'b0;

  // Reference model state, derived from the requirements
  logic [31:0] m_lvl = '0, m_dir = '0, m_scr = '0, m_rd = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare outputs with queued expectations away from the edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "rsp_rdata", rsp_rdata, e.rdata);
      chk(e.tag, "acc_err", {31'b0, acc_err}, {31'b0, e.err});
      chk(e.tag, "pin_out", pin_out, e.pout);
      chk(e.tag, "pin_oe", pin_oe, e.poe);
      chk("R10", "irq", {23'b0, irq_high, irq_low}, 32'h0);
    end
  end

  task automatic push(input string tag, input logic err);
    exp_t e;
    e.tag = tag; e.due = cyc + 1; e.rdata = m_rd; e.err = err;
    e.pout = m_lvl; e.poe = m_dir;
    sb.push_back(e);
  endtask

  // Driver: issue one request and predict its outcome
  task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input string tag);
    logic err;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    err = 1'b0;
    if (w) begin
      case (a)
        8'h04: m_dir = d;
        8'h08: if ((m_dir & d) != 0) m_lvl = m_lvl | d; else err = 1'b1;
        8'h0C: if ((m_dir & d) != 0) m_lvl = m_lvl & ~d; else err = 1'b1;
        8'h20: m_scr = d;
        8'h10, 8'h14, 8'h18: ;
        default: err = 1'b1;
      endcase
    end else begin
      case (a)
        8'h00: m_rd = m_lvl;
        8'h04: m_rd = m_dir;
        8'h20: m_rd = m_scr;
        default: begin m_rd = '0; err = 1'b1; end
      endcase
    end
    push(tag, err);
  endtask

  task automatic idle(input string tag);
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    push(tag, 1'b0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "pin_oe in reset", pin_oe, 32'h0);
    chk("R1", "pin_out in reset", pin_out, 32'h0);
    chk("R1", "rdata in reset", rsp_rdata, 32'h0);
    chk("R1", "err in reset", {31'b0, acc_err}, 32'h0);
    @(posedge clk); #1; rst_n = 1'b1;
    idle("R1 after release");
    acc(1'b0, 8'h00, 0, "R1 level zero");
    acc(1'b0, 8'h04, 0, "R1 dir zero");
    acc(1'b0, 8'h20, 0, "R1 scratch zero");
    // Direction and mask writes
    acc(1'b1, 8'h04, 32'h0000_00FF, "R3 dir load");
    acc(1'b0, 8'h04, 0, "R2 dir read");
    acc(1'b1, 8'h08, 32'h0000_0F0F, "R4 set incl input bits");
    acc(1'b0, 8'h00, 0, "R2 level read");
    acc(1'b1, 8'h0C, 32'h0000_0101, "R5 clear");
    acc(1'b0, 8'h00, 0, "R5 level read");
    // Rejected mask followed at once by a level read
    acc(1'b1, 8'h08, 32'hFF00_0000, "R6 set rejected");
    acc(1'b0, 8'h00, 0, "R9 read after reject");
    acc(1'b1, 8'h0C, 32'h0000_0F00, "R6 clear rejected");
    idle("R9 idle after reject");
    // Edge slots
    acc(1'b1, 8'h10, 32'hFFFF_FFFF, "R7 edge rise");
    acc(1'b1, 8'h14, 32'hFFFF_FFFF, "R7 edge fall");
    acc(1'b1, 8'h18, 32'hFFFF_FFFF, "R7 edge status");
    // Illegal offsets
    acc(1'b0, 8'h08, 0, "R8 read set port");
    acc(1'b1, 8'h04, 32'hA5A5_0F0F, "R9 legal after bad read");
    acc(1'b0, 8'h24, 0, "R8 read unmapped");
    acc(1'b0, 8'h02, 0, "R8 read misaligned");
    acc(1'b1, 8'h30, 32'h1234_5678, "R8 write unmapped");
    acc(1'b1, 8'h06, 32'h0000_0000, "R8 write misaligned");
    acc(1'b0, 8'h04, 0, "R8 dir unchanged");
    // Scratch word
    acc(1'b1, 8'h20, 32'hDEAD_BEEF, "R11 scratch write");
    acc(1'b0, 8'h20, 0, "R11 scratch read");
    idle("R2 rdata held");
    // Wide set/clear with new direction
    acc(1'b1, 8'h08, 32'hFFFF_FFFF, "R4 set all");
    acc(1'b1, 8'h0C, 32'h8000_0001, "R5 clear ends");
    acc(1'b1, 8'h04, 32'h0000_0000, "R3 all inputs");
    acc(1'b1, 8'h0C, 32'hFFFF_FFFF, "R6 clear no outputs");
    acc(1'b0, 8'h00, 0, "R6 level kept");
    idle("R9 final idle");
    idle("R2 final hold");
    wait (sb.size() == 0);
    @(negedge clk);
    finish_up();
  end

endmodule